// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block maps 32-bit virtual addresses onto physical addresses in 8 KB pages. A small, fully associative cache of translations sits in front of a page table held in memory. Each lookup compares the upper 19 address bits against every cached tag. A hit in a permitted mode returns the physical address in the same cycle. A hit that breaks the entry's permissions raises a fault and issues no address.

On a miss, the block raises a fetch request whose address is the table base plus four times the page number. It then waits for an external agent to return the entry on the refill port. The requester keeps its request asserted and stalls until it sees either ready or fault.

A command port installs or updates entries, invalidates the whole cache and loads the table base. It acts only when the current mode is kernel.

Top module: `page_xlate`

## Requirements
- R1: A request in kernel mode, or to a user-accessible entry, that hits with a permitted access raises `rsp_ready` in the same cycle. `rsp_paddr` is then the entry's frame (entry bits 21:3) followed by virtual address bits 12:0 unchanged.
- R2: A request that misses raises no response. From the next cycle, `miss_req` stays high until a refill arrives, and `miss_addr` equals table base + VPN×4, where VPN is virtual address bits 31:13.
- R3: A refill whose bit 0 (valid) is set is stored in the cache and clears `miss_req`. One cycle later the still-held request hits.
- R4: A refill whose valid bit is clear raises `rsp_fault` in the refill cycle, is not stored, and clears `miss_req`.
- R5: In user mode (`user_mode`=1), a hit on an entry whose bit 2 (user access) is clear raises `rsp_fault` instead of `rsp_ready`, with `rsp_paddr` zero.
- R6: A write (`req_kind`=01) that hits an entry whose bit 1 (write permit) is clear faults in either mode. Reads (00) and fetches (10) ignore that bit.
- R7: Commands on the command port have no effect while `user_mode` is 1.
- R8: A kernel flush (`cfg_op`=11) invalidates every cached entry in one cycle.
- R9: A kernel install (`cfg_op`=10) whose page number is already cached overwrites that entry in place. An install with the valid bit clear removes a matching entry and does nothing otherwise. A kernel base load uses `cfg_op`=01.
- R10: New entries go into slots in round-robin order, and the order is not reset by a flush. Nine distinct valid refills after a flush therefore evict the first of them.
- R11: `rsp_ready` and `rsp_fault` are never high together. Both are low, and `rsp_paddr` is zero, when `req_valid` is low.
- R12: After reset the cache is empty, the table base is zero and `miss_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_mode | input | 1 | Current mode: 1 user, 0 kernel |
| req_valid | input | 1 | Translation request, held until ready or fault |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch |
| rsp_ready | output | 1 | Translation issued |
| rsp_paddr | output | 32 | Physical address, zero unless ready |
| rsp_fault | output | 1 | Access refused |
| miss_req | output | 1 | Page-table entry fetch wanted |
| miss_addr | output | 32 | Address of the wanted entry |
| fill_valid | input | 1 | Refill entry present |
| fill_pte | input | 22 | Refill entry: frame[21:3], user[2], write[1], valid[0] |
| cfg_valid | input | 1 | Command strobe |
| cfg_op | input | 2 | 01 load base, 10 install, 11 flush |
| cfg_vpn | input | 19 | Page number for install |
| cfg_pte | input | 22 | Entry for install, same layout as fill_pte |
| cfg_base | input | 32 | New table base |

## Verification
The hardest case to reach from the ports is eviction: all eight slots must be full of distinct valid pages, and the next refill must land on the oldest one. The stimulus flushes the cache, walks nine fresh pages through the full miss-and-refill handshake, then probes the first one for a miss and the last one for a hit. A random mix over twelve pages, with installs and flushes interleaved, keeps the cache oversubscribed so that evictions also occur between random permission checks.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 13,
  parameter int ENTRIES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    user_mode,
  input  logic                    req_valid,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic [1:0]              req_kind,
  output logic                    rsp_ready,
  output logic [PA_W-1:0]         rsp_paddr,
  output logic                    rsp_fault,
  output logic                    miss_req,
  output logic [PA_W-1:0]         miss_addr,
  input  logic                    fill_valid,
  input  logic [PA_W-OFF_W+2:0]   fill_pte,
  input  logic                    cfg_valid,
  input  logic [1:0]              cfg_op,
  input  logic [VA_W-OFF_W-1:0]   cfg_vpn,
  input  logic [PA_W-OFF_W+2:0]   cfg_pte,
  input  logic [PA_W-1:0]         cfg_base
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int PTE_W = PFN_W + 3;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [1:0] OP_BASE = 2'b01, OP_INST = 2'b10, OP_FLUSH = 2'b11;
  localparam logic [1:0] KIND_WR = 2'b01;

  logic [ENTRIES-1:0] v_q, w_q, u_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;
  logic               wait_q;
  logic [VPN_W-1:0]   miss_vpn_q;
  logic [PA_W-1:0]    miss_addr_q, base_q;

  wire [VPN_W-1:0] req_vpn = req_vaddr[VA_W-1:OFF_W];

  logic hit, wmatch;
  logic [IDX_W-1:0] hit_idx, widx;
  logic [VPN_W-1:0] wr_vpn;
  logic [PTE_W-1:0] wr_pte;

  always_comb begin
    hit = 1'b0; hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (v_q[i] && tag_q[i] == req_vpn) begin hit = 1'b1; hit_idx = IDX_W'(i); end
  end

  wire fill_acc = wait_q & fill_valid;
  wire cfg_acc  = cfg_valid & ~user_mode & ~fill_acc;
  wire base_ld  = cfg_acc & (cfg_op == OP_BASE);
  wire flush    = cfg_acc & (cfg_op == OP_FLUSH);
  wire inst     = cfg_acc & (cfg_op == OP_INST);

  assign wr_vpn = fill_acc ? miss_vpn_q : cfg_vpn;
  assign wr_pte = fill_acc ? fill_pte : cfg_pte;

  always_comb begin
    wmatch = 1'b0; widx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (v_q[i] && tag_q[i] == wr_vpn) begin wmatch = 1'b1; widx = IDX_W'(i); end
  end

  wire wr_en = (fill_acc & fill_pte[0]) | (inst & (cfg_pte[0] | wmatch));
  wire [IDX_W-1:0] slot = wmatch ? widx : rr_q;
  wire go_miss = req_valid & ~wait_q & ~hit;

  wire look    = req_valid & ~wait_q & hit;
  wire perm_ok = (~user_mode | u_q[hit_idx]) & ((req_kind != KIND_WR) | w_q[hit_idx]);

  assign rsp_ready = look & perm_ok;
  assign rsp_fault = (look & ~perm_ok) | (fill_acc & ~fill_pte[0]);
  assign rsp_paddr = rsp_ready ? {pfn_q[hit_idx], req_vaddr[OFF_W-1:0]} : '0;
  assign miss_req  = wait_q;
  assign miss_addr = miss_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0; w_q <= '0; u_q <= '0; rr_q <= '0;
      wait_q <= 1'b0; miss_vpn_q <= '0; miss_addr_q <= '0; base_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin tag_q[i] <= '0; pfn_q[i] <= '0; end
    end else begin
      if (go_miss) begin
        wait_q      <= 1'b1;
        miss_vpn_q  <= req_vpn;
        miss_addr_q <= base_q + {{(PA_W-VPN_W-2){1'b0}}, req_vpn, 2'b00};
      end else if (fill_acc) begin
        wait_q <= 1'b0;
      end
      if (base_ld) base_q <= cfg_base;
      if (flush) begin
        v_q <= '0;
      end else if (wr_en) begin
        v_q[slot]   <= wr_pte[0];
        w_q[slot]   <= wr_pte[1];
        u_q[slot]   <= wr_pte[2];
        tag_q[slot] <= wr_vpn;
        pfn_q[slot] <= wr_pte[PTE_W-1:3];
        if (!wmatch) rr_q <= (rr_q == IDX_W'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  assert_resp_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ready && rsp_fault));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!rsp_ready && rsp_paddr == '0));
  assert_miss_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req && !fill_valid) |=> (miss_req && $stable(miss_addr)));
  assert_fill_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req && fill_valid) |=> !miss_req);
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !user_mode && cfg_op == OP_FLUSH && !(miss_req && fill_valid)) |=> (v_q == '0));
  assert_user_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && user_mode && !(miss_req && fill_valid)) |=> ($stable(base_q) && $stable(v_q)));
endmodule

// File: tb/test_page_xlate.sv
`timescale 1ns/1ps
module test_page_xlate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic user_mode = 1'b0, req_valid = 1'b0, fill_valid = 1'b0, cfg_valid = 1'b0;
  logic [31:0] req_vaddr = '0, cfg_base = '0;
  logic [1:0]  req_kind = '0, cfg_op = '0;
  logic [21:0] fill_pte = '0, cfg_pte = '0;
  logic [18:0] cfg_vpn = '0;
  logic rsp_ready, rsp_fault, miss_req;
  logic [31:0] rsp_paddr, miss_addr;

  page_xlate i_page_xlate (.*);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [18:0] m_vpn [8];
  logic [21:0] m_pte [8];
  bit          m_v   [8];
  int          m_rr = 0;
  logic [31:0] m_base = '0;
  bit          done = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [21:0] pte_of(logic [18:0] vpn);
    logic [18:0] fr;
    fr = vpn ^ 19'h2b3c1;
    return {fr, vpn[1], vpn[0], (vpn % 7) != 3};
  endfunction

  function automatic int m_find(logic [18:0] vpn);
    for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic m_write(logic [18:0] vpn, logic [21:0] p);
    int idx;
    idx = m_find(vpn);
    if (idx >= 0) begin m_pte[idx] = p; m_v[idx] = p[0]; end
    else if (p[0]) begin m_vpn[m_rr] = vpn; m_pte[m_rr] = p; m_v[m_rr] = 1; m_rr = (m_rr + 1) % 8; end
  endtask

  task automatic expect_resp(int idx, logic [12:0] off, logic [1:0] kind, bit user);
    logic [21:0] p;
    bit ok;
    string tag;
    p = m_pte[idx];
    ok = (!user || p[2]) && (kind != 2'b01 || p[1]);
    tag = ok ? "R1" : (user && !p[2]) ? "R5" : "R6";
    chk(tag, rsp_ready, ok);
    chk(tag, rsp_fault, !ok);
    chk(tag, rsp_paddr, ok ? {p[21:3], off} : 32'h0);
  endtask

  task automatic access(logic [18:0] vpn, logic [12:0] off, logic [1:0] kind, bit user);
    int idx;
    logic [21:0] p;
    @(negedge clk);
    req_valid = 1; req_vaddr = {vpn, off}; req_kind = kind; user_mode = user;
    #5;
    idx = m_find(vpn);
    if (idx >= 0) expect_resp(idx, off, kind, user);
    else begin
      chk("R2", {rsp_ready, rsp_fault}, 0);
      @(negedge clk); #5;
      chk("R2", miss_req, 1);
      chk("R2", miss_addr, m_base + {11'b0, vpn, 2'b00});
      @(negedge clk); #5;
      chk("R2", miss_req, 1);
      p = pte_of(vpn);
      fill_valid = 1; fill_pte = p; #1;
      if (!p[0]) chk("R4", rsp_fault, 1); else chk("R3", rsp_ready, 0);
      @(posedge clk);
      if (p[0]) m_write(vpn, p);
      @(negedge clk); fill_valid = 0; #5;
      if (p[0]) begin
        chk("R3", miss_req, 0);
        expect_resp(m_find(vpn), off, kind, user);
      end else begin
        chk("R4", miss_req, 0);
        chk("R4", rsp_fault, 0);
      end
    end
    req_valid = 0;
  endtask

  task automatic cmd(logic [1:0] op, logic [18:0] vpn, logic [21:0] p, logic [31:0] base, bit user);
    @(negedge clk);
    cfg_valid = 1; cfg_op = op; cfg_vpn = vpn; cfg_pte = p; cfg_base = base; user_mode = user;
    @(negedge clk);
    cfg_valid = 0;
    if (!user) begin
      if (op == 2'b01) m_base = base;
      else if (op == 2'b10) m_write(vpn, p);
      else if (op == 2'b11) for (int i = 0; i < 8; i++) m_v[i] = 0;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [18:0] ring [9];
    int n;
    void'($urandom(32'h1d2c3b4a));
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_vpn[i] = '0; m_pte[i] = '0; end
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #5;
    chk("R12", miss_req, 0);
    chk("R12", miss_addr, 0);
    chk("R11", {rsp_ready, rsp_fault}, 0);
    chk("R11", rsp_paddr, 0);

    access(19'd7, 13'h0abc, 2'b00, 0);           // base zero R12
    cmd(2'b01, '0, '0, 32'h0010_0000, 0);
    access(19'd5, 13'h1234, 2'b00, 0);
    access(19'd5, 13'h0007, 2'b10, 0);           // R1 hit
    access(19'd5, 13'h0100, 2'b00, 1);           // R5 user fault
    access(19'd4, 13'h0020, 2'b01, 0);           // R6 write fault
    access(19'd4, 13'h0020, 2'b10, 0);           // R6 fetch allowed
    access(19'd7, 13'h1fff, 2'b01, 1);           // R1 user write allowed
    cmd(2'b01, '0, '0, 32'hdead_0000, 1);        // R7 ignored base
    cmd(2'b11, '0, '0, '0, 1);                   // R7 ignored flush
    access(19'd9, 13'h0001, 2'b00, 0);           // R7 miss address uses old base
    access(19'd5, 13'h0002, 2'b00, 0);           // R7 still cached
    access(19'd3, 13'h0003, 2'b00, 0);           // R4 invalid refill
    access(19'd3, 13'h0003, 2'b00, 0);           // R4 not stored, misses again
    cmd(2'b10, 19'd5, {19'h12345, 3'b111}, '0, 0);
    access(19'd5, 13'h0444, 2'b01, 1);           // R9 updated in place
    cmd(2'b10, 19'd5, {19'h00000, 3'b110}, '0, 0);
    @(negedge clk); req_valid = 1; req_vaddr = {19'd5, 13'h0}; req_kind = 0; user_mode = 0; #5;
    chk("R9", rsp_ready, 0);
    req_valid = 0;
    cmd(2'b11, '0, '0, '0, 0);
    @(negedge clk); req_valid = 1; req_vaddr = {19'd7, 13'h0}; req_kind = 0; user_mode = 0; #5;
    chk("R8", rsp_ready, 0);
    req_valid = 0;

    n = 0;
    for (int v = 200; n < 9; v++) begin
      if (pte_of(19'(v))[0]) begin ring[n] = 19'(v); n++; end
    end
    for (int k = 0; k < 9; k++) access(ring[k], 13'h0010, 2'b00, 0);
    @(negedge clk); req_valid = 1; req_vaddr = {ring[0], 13'h0}; req_kind = 0; user_mode = 0; #5;
    chk("R10", rsp_ready, 0);
    req_valid = 0;
    @(negedge clk); req_valid = 1; req_vaddr = {ring[8], 13'h0}; #5;
    chk("R10", rsp_ready, 1);
    req_valid = 0;

    for (int it = 0; it < 300; it++) begin
      int r;
      logic [18:0] pv;
      r = $urandom % 100;
      pv = 19'h40000 | 19'($urandom % 12);
      if (r < 3) cmd(2'b11, '0, '0, '0, 0);
      else if (r < 8) cmd(2'b10, pv, 22'($urandom), '0, 0);
      else if (r < 11) cmd(2'($urandom), pv, 22'($urandom), $urandom, 1);
      else access(pv, 13'($urandom), 2'($urandom % 3), bit'($urandom % 2));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule